// File: doc/BRIEF.md
# Occupancy-Driven Climate Controller

This block keeps a 3-bit model of room temperature, where codes 0 to 7 stand for 20 to 27 degrees. While people are present it moves the temperature one degree at a time toward a desired setpoint. The step period depends on how many people are inside: a small group gets a faster step than a crowd.

When the room empties, control stays on for a hold interval and keeps regulating. After that the controller switches off, and the temperature drifts toward the outside value at a slower rate. A further interval later the temperature display is blanked. If anyone re-enters during either interval, the controller returns to full operation at once.

All delays and step periods are counted in ticks of an external timebase. With the default parameters one tick is taken to be 0.5 s. Reset is synchronous and active low.

Top module: `vault_climate_ctrl`

## Requirements
- R1: While reset is held, the room temperature loads the outside temperature code, and climate-on and display-enable are low. All three keep these values on the first cycle after reset is released.
- R2: A non-zero people count sets climate-on and display-enable high on the next clock edge.
- R3: While control is on, each step moves the temperature one code toward the desired code: down when above, up when below. Once the temperature equals the target, it holds and the step phase restarts.
- R4: While control is on, the step period is FAST_TICKS ticks (default 1) when the count is 0 to 5, and SLOW_TICKS ticks (default 2) when the count is 6 to 9.
- R5: People-count codes 10 to 15 are treated as 9. They therefore select the slow step period and keep control on.
- R6: When the count drops to zero, control stays on and keeps regulating for HOLD_TICKS ticks (default 20, 10 s). Climate-on falls on the tick that completes this hold interval.
- R7: While control is off, the temperature steps one code toward the outside temperature every DRIFT_TICKS ticks (default 4, 2 s).
- R8: Display-enable falls on the BLANK_TICKS-th tick (default 40, 20 s) after climate-on falls. Display-enable is never low while climate-on is high.
- R9: A non-zero count during the hold or blank interval returns control to on at the next edge. A later empty room then starts a full hold interval again.
- R10: The temperature changes only on a clock edge where the tick is high, and by at most one code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle timebase pulse |
| outside_temp | input | 3 | Outside temperature code |
| desired_temp | input | 3 | Setpoint code |
| people | input | 4 | Occupancy count |
| room_temp | output | 3 | Current room temperature code |
| climate_on | output | 1 | Climate control active |
| display_en | output | 1 | Temperature display enable |

## Verification
A change in the people count reaches climate-on and display-enable one clock edge later. Temperature steps and timer expiries land on the clock edge that samples the tick which completes a period. The bench therefore waits three clocks after every input change before it issues ticks, so that the mode is settled. Each tick lasts one full clock, and every output is sampled on the falling edge after the last tick of a row. Expected values in each row are counted in whole ticks from the requirement periods.

// File: rtl/vault_climate_pkg.sv
package vault_climate_pkg;
   typedef enum logic [1:0] {
      MODE_ACTIVE = 2'd0,
      MODE_LINGER = 2'd1,
      MODE_COAST  = 2'd2,
      MODE_DARK   = 2'd3
   } vc_mode_e;

   function automatic int vc_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/vc_occupancy.sv
module vc_occupancy #(
   parameter int CNT_W       = 4,
   parameter int MAX_PEOPLE  = 9,
   parameter int CROWD_LIMIT = 5,
   parameter int FAST_TICKS  = 1,
   parameter int SLOW_TICKS  = 2,
   parameter int DRIFT_TICKS = 4,
   parameter int PER_W       = 3
) (
   input  logic [CNT_W-1:0] people,
   input  logic             ctrl_on,
   output logic             occupied,
   output logic [PER_W-1:0] period
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   logic [CNT_W-1:0] eff_count;

   generate
      if (MAX_PEOPLE < CNT_MAX) begin : g_clamp
         assign eff_count = (people > CNT_W'(MAX_PEOPLE)) ? CNT_W'(MAX_PEOPLE) : people;
      end else begin : g_pass
         assign eff_count = people;
      end
   endgenerate

   assign occupied = (eff_count != '0);

   always_comb begin
      if (!ctrl_on)
         period = PER_W'(DRIFT_TICKS);
      else if (eff_count > CNT_W'(CROWD_LIMIT))
         period = PER_W'(SLOW_TICKS);
      else
         period = PER_W'(FAST_TICKS);
   end
endmodule

// File: rtl/vc_mode_fsm.sv
module vc_mode_fsm
   import vault_climate_pkg::*;
#(
   parameter int HOLD_TICKS  = 20,
   parameter int BLANK_TICKS = 40
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     occupied,
   output vc_mode_e mode
);
   localparam int TMR_MAX = (HOLD_TICKS > BLANK_TICKS) ? HOLD_TICKS : BLANK_TICKS;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);

   logic [TMR_W-1:0] timer;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode  <= MODE_DARK;
         timer <= '0;
      end else if (occupied) begin
         mode  <= MODE_ACTIVE;
         timer <= '0;
      end else begin
         unique case (mode)
            MODE_ACTIVE: begin
               mode  <= MODE_LINGER;
               timer <= '0;
            end
            MODE_LINGER: if (tick) begin
               if (timer == TMR_W'(HOLD_TICKS - 1)) begin
                  mode  <= MODE_COAST;
                  timer <= '0;
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            MODE_COAST: if (tick) begin
               if (timer == TMR_W'(BLANK_TICKS - 1)) begin
                  mode  <= MODE_DARK;
                  timer <= '0;
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            default: timer <= '0;
         endcase
      end
   end
endmodule

// File: rtl/vc_temp_stepper.sv
module vc_temp_stepper #(
   parameter int TEMP_W = 3,
   parameter int PER_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ctrl_on,
   input  logic [TEMP_W-1:0] target,
   input  logic [TEMP_W-1:0] reset_val,
   input  logic [PER_W-1:0]  period,
   output logic [TEMP_W-1:0] temp
);
   logic             on_q;
   logic [PER_W-1:0] phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         temp  <= reset_val;
         phase <= '0;
         on_q  <= 1'b0;
      end else begin
         on_q <= ctrl_on;
         if (ctrl_on != on_q) begin
            phase <= '0;
         end else if (tick) begin
            if (temp == target) begin
               phase <= '0;
            end else if (phase >= period - PER_W'(1)) begin
               phase <= '0;
               temp  <= (temp < target) ? temp + 1'b1 : temp - 1'b1;
            end else begin
               phase <= phase + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/vault_climate_ctrl.sv
module vault_climate_ctrl
   import vault_climate_pkg::*;
#(
   parameter int TEMP_W      = 3,
   parameter int CNT_W       = 4,
   parameter int MAX_PEOPLE  = 9,
   parameter int CROWD_LIMIT = 5,
   parameter int FAST_TICKS  = 1,
   parameter int SLOW_TICKS  = 2,
   parameter int DRIFT_TICKS = 4,
   parameter int HOLD_TICKS  = 20,
   parameter int BLANK_TICKS = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [TEMP_W-1:0] outside_temp,
   input  logic [TEMP_W-1:0] desired_temp,
   input  logic [CNT_W-1:0]  people,
   output logic [TEMP_W-1:0] room_temp,
   output logic              climate_on,
   output logic              display_en
);
   localparam int PER_MAX = vc_max3(FAST_TICKS, SLOW_TICKS, DRIFT_TICKS);
   localparam int PER_W   = $clog2(PER_MAX + 1);

   generate
      if (FAST_TICKS < 1 || SLOW_TICKS < 1 || DRIFT_TICKS < 1) begin : g_bad_period
         $error("vault_climate_ctrl: step periods must be at least one tick");
      end
      if (HOLD_TICKS < 1 || BLANK_TICKS < 1) begin : g_bad_delay
         $error("vault_climate_ctrl: delays must be at least one tick");
      end
      if (MAX_PEOPLE >= (1 << CNT_W) || CROWD_LIMIT >= MAX_PEOPLE) begin : g_bad_count
         $error("vault_climate_ctrl: occupancy limits do not fit CNT_W");
      end
   endgenerate

   vc_mode_e         mode;
   logic             occupied;
   logic             ctrl_on;
   logic [PER_W-1:0] period;
   logic [TEMP_W-1:0] target;

   assign ctrl_on = (mode == MODE_ACTIVE) || (mode == MODE_LINGER);
   assign target  = ctrl_on ? desired_temp : outside_temp;

   vc_occupancy #(
      .CNT_W(CNT_W), .MAX_PEOPLE(MAX_PEOPLE), .CROWD_LIMIT(CROWD_LIMIT),
      .FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS),
      .DRIFT_TICKS(DRIFT_TICKS), .PER_W(PER_W)
   ) i_occ (
      .people(people), .ctrl_on(ctrl_on), .occupied(occupied), .period(period)
   );

   vc_mode_fsm #(
      .HOLD_TICKS(HOLD_TICKS), .BLANK_TICKS(BLANK_TICKS)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .occupied(occupied), .mode(mode)
   );

   vc_temp_stepper #(
      .TEMP_W(TEMP_W), .PER_W(PER_W)
   ) i_step (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_on(ctrl_on),
      .target(target), .reset_val(outside_temp), .period(period), .temp(room_temp)
   );

   assign climate_on = ctrl_on;
   assign display_en = (mode != MODE_DARK);
endmodule

// File: rtl/vault_climate_chk.sv
module vault_climate_chk #(
   parameter int TEMP_W = 3,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [TEMP_W-1:0] outside_temp,
   input logic [TEMP_W-1:0] desired_temp,
   input logic [CNT_W-1:0]  people,
   input logic [TEMP_W-1:0] room_temp,
   input logic              climate_on,
   input logic              display_en
);
   assert_reset_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (room_temp == $past(outside_temp) && !climate_on && !display_en));

   assert_occupied_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (people != '0) |=> (climate_on && display_en));

   assert_still_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(room_temp));

   assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ({1'b0, room_temp} == {1'b0, $past(room_temp)} ||
                {1'b0, room_temp} == {1'b0, $past(room_temp)} + 1'b1 ||
                {1'b0, room_temp} + 1'b1 == {1'b0, $past(room_temp)}));

   assert_drift_direction_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!climate_on && people == '0) |=>
         ($stable(room_temp) || ((room_temp > $past(room_temp)) == ($past(outside_temp) > $past(room_temp)))));

   assert_display_covers_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      climate_on |-> display_en);

   assert_blank_only_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(display_en) |-> !$past(climate_on));

   assert_ctrl_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (climate_on && people != '0 && tick && room_temp == desired_temp) |=> $stable(room_temp));
endmodule

bind vault_climate_ctrl vault_climate_chk #(.TEMP_W(TEMP_W), .CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .outside_temp(outside_temp),
   .desired_temp(desired_temp), .people(people), .room_temp(room_temp),
   .climate_on(climate_on), .display_en(display_en)
);

// File: tb/test_vault_climate_ctrl.sv
module test_vault_climate_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [2:0] outside_temp = 3'd3;
   logic [2:0] desired_temp = 3'd6;
   logic [3:0] people = 4'd0;
   logic [2:0] room_temp;
   logic       climate_on;
   logic       display_en;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vault_climate_ctrl i_vault_climate_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .outside_temp(outside_temp),
      .desired_temp(desired_temp), .people(people), .room_temp(room_temp),
      .climate_on(climate_on), .display_en(display_en)
   );

   // row: req(4) outside(3) desired(3) people(4) ticks(6) exp_temp(3) exp_on(1) exp_disp(1)
   localparam int NROWS = 16;
   localparam logic [24:0] VEC [NROWS] = '{
      {4'd3, 3'd3, 3'd6, 4'd2,  6'd2,  3'd5, 1'b1, 1'b1},  // R3 heat toward setpoint
      {4'd3, 3'd3, 3'd6, 4'd2,  6'd2,  3'd6, 1'b1, 1'b1},  // R3 stop at setpoint
      {4'd4, 3'd3, 3'd2, 4'd7,  6'd3,  3'd5, 1'b1, 1'b1},  // R4 slow period when crowded
      {4'd5, 3'd3, 3'd2, 4'd12, 6'd3,  3'd3, 1'b1, 1'b1},  // R5 count 12 acts as 9
      {4'd6, 3'd3, 3'd2, 4'd0,  6'd19, 3'd2, 1'b1, 1'b1},  // R6 still on inside hold
      {4'd6, 3'd3, 3'd2, 4'd0,  6'd1,  3'd2, 1'b0, 1'b1},  // R6 off at hold end
      {4'd7, 3'd5, 3'd2, 4'd0,  6'd4,  3'd3, 1'b0, 1'b1},  // R7 drift one per 4 ticks
      {4'd9, 3'd5, 3'd0, 4'd3,  6'd0,  3'd3, 1'b1, 1'b1},  // R9 re-entry while coasting
      {4'd3, 3'd5, 3'd0, 4'd0,  6'd10, 3'd0, 1'b1, 1'b1},  // R3 hold keeps regulating
      {4'd9, 3'd5, 3'd0, 4'd1,  6'd0,  3'd0, 1'b1, 1'b1},  // R9 re-entry inside hold
      {4'd9, 3'd5, 3'd0, 4'd0,  6'd19, 3'd0, 1'b1, 1'b1},  // R9 hold restarted in full
      {4'd6, 3'd5, 3'd0, 4'd0,  6'd1,  3'd0, 1'b0, 1'b1},  // R6 off again
      {4'd8, 3'd5, 3'd0, 4'd0,  6'd39, 3'd5, 1'b0, 1'b1},  // R8 display kept before limit
      {4'd8, 3'd5, 3'd0, 4'd0,  6'd1,  3'd5, 1'b0, 1'b0},  // R8 display blanked
      {4'd7, 3'd1, 3'd0, 4'd0,  6'd8,  3'd3, 1'b0, 1'b0},  // R7 drift continues when dark
      {4'd2, 3'd1, 3'd7, 4'd4,  6'd0,  3'd3, 1'b1, 1'b1}   // R2 wake from dark
   };

   task automatic check(input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, got, exp);
      end
   endtask

   task automatic pulse_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset state, observed while reset is held and just after release
      check("R1 temp in reset", room_temp, 3);
      check("R1 climate_on in reset", climate_on, 0);
      check("R1 display_en in reset", display_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 temp after release", room_temp, 3);
      check("R1 display_en after release", display_en, 0);

      for (int r = 0; r < NROWS; r++) begin
         logic [24:0] v;
         string tag;
         v = VEC[r];
         outside_temp = v[20:18];
         desired_temp = v[17:15];
         people       = v[14:11];
         settle();
         pulse_ticks(int'(v[10:5]));
         @(negedge clk);
         tag = $sformatf("R%0d row %0d", v[24:21], r);
         check({tag, " room_temp"}, room_temp, v[4:2]);
         check({tag, " climate_on"}, climate_on, v[1]);
         check({tag, " display_en"}, display_en, v[0]);
      end

      // R10: no change without a tick even though far from the setpoint
      desired_temp = 3'd7;
      people = 4'd2;
      settle();
      repeat (20) @(negedge clk);
      check("R10 temp without tick", room_temp, 3);
      pulse_ticks(1);
      @(negedge clk);
      check("R10 single step per tick", room_temp, 4);

      // R4: exactly five people still uses the fast period
      people = 4'd5;
      desired_temp = 3'd6;
      settle();
      pulse_ticks(2);
      @(negedge clk);
      check("R4 five people fast", room_temp, 6);

      // R1: a second reset reloads the outside code
      outside_temp = 3'd6;
      people = 4'd0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reload temp", room_temp, 6);
      check("R1 reload climate_on", climate_on, 0);
      check("R1 reload display_en", display_en, 0);

      done = 1'b1;
      finish_run();
   end
endmodule